// File: doc/BRIEF.md
# Attention Register Bank with Conditional Write

This block collects hardware exception events into a bank of byte-wide attention registers that a host reads and clears over a simple control bus. Every event input sets one attention bit. The bit stays set until the host clears it. Each attention register has a notify register with the same layout. An attention bit can reach the interrupt only while its notify bit is set. The masked attentions of each register are reduced to one summary bit. The summary bits, gated by a summary notify register, drive a single interrupt line.

The host clears attention bits with a conditional write. It first loads a shared compare register with the values it believes the bits hold, and then writes the attention register. A bit takes the written value only where the compare bit equals the bit's present value. A bit that an event set after the host last read it therefore does not match, and it survives the clear. The first attention register is the state register. Its three stop bits (D2..D0) come out of reset set, and its D7 bit collects bus and state machine errors.

Top module: `attn_bank`

## Requirements
- R1: After reset, the state attention register (address 0x0) reads 0x07. All other attention registers, all notify registers, the summary notify register, the compare register and the summary read 0x00, and `irq` is low.
- R2: A high level on event input bit `ev[8*r+b]` at a clock edge sets bit b of attention register r (address 2r). The bit stays set until the host clears it with a write.
- R3: A write to attention register r (address 2r) changes bit b to `wdata[b]` only when bit b of the compare register (address 0xC) equals the current value of that bit. Every other bit keeps its value.
- R4: When an event and a host write that clears the same attention bit fall in the same cycle, the bit ends up set.
- R5: Notify register r (address 2r+1), the summary notify register (address 0xB) and the compare register are plain read/write registers.
- R6: The summary register (address 0xA) holds, in bit 7-r, the OR over register r of (attention AND notify), for registers r = 0..4. Bits 2..0 read zero.
- R7: Writes to the summary register have no effect on the value read from it.
- R8: `irq` is the OR over bits of (summary AND summary notify).
- R9: Addresses 0xD..0xF read zero, and writes to them change no register.
- R10: `rdata` is zero while `rd` is low. While `rd` is high it shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, captured at the clock edge |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational from the address |
| ev | input | 40 | Event inputs, 8 per attention register, register r in bits 8r+7..8r |
| irq | output | 1 | Interrupt request |

## Verification
The conditional write is tried with three compare patterns:
- a compare value that matches every set bit, to show that a full clear works;
- a compare value that matches only some bits, to show which bits change and which hold;
- a compare value of zero over bits that are zero, to show that a write can also set bits.

An event that arrives in the same cycle as a matching clear separates set priority from write priority. The masking path is tried in three ways:
- a notify mask that excludes the only live attention bit, which must keep the summary bit clear;
- a summary notify value that selects a live summary bit and then an idle one, which must raise `irq` and then drop it;
- a late event under an already-open mask, which must raise `irq` with no further write.

// File: rtl/attn_bank.sv
module attn_bank #(
  parameter int NREG = 5,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [7:0] STATE_RST = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               wr,
  input  logic               rd,
  output logic [DW-1:0]      rdata,
  input  logic [NREG*DW-1:0] ev,
  output logic               irq
);
  localparam logic [AW-1:0] SUM_A = AW'(2*NREG);
  localparam logic [AW-1:0] SNT_A = AW'(2*NREG+1);
  localparam logic [AW-1:0] CMP_A = AW'(2*NREG+2);

  logic [NREG-1:0][DW-1:0] attn, ntfy;
  logic [DW-1:0] cmp, snt, sum_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
      snt <= '0;
    end else if (wr) begin
      if (addr == CMP_A) cmp <= wdata;
      if (addr == SNT_A) snt <= wdata;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_reg
      logic          hit_a, hit_n;
      logic [DW-1:0] wmask, evs, nxt;
      assign hit_a = wr && addr == AW'(2*i);
      assign hit_n = wr && addr == AW'(2*i+1);
      assign evs   = ev[i*DW +: DW];
      assign wmask = hit_a ? ~(cmp ^ attn[i]) : '0;
      assign nxt   = (attn[i] & ~wmask) | (wdata & wmask) | evs;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          attn[i] <= (i == 0) ? DW'(STATE_RST) : '0;
          ntfy[i] <= '0;
        end else begin
          attn[i] <= nxt;
          if (hit_n) ntfy[i] <= wdata;
        end
      end

      assign sum_v[DW-1-i] = |(attn[i] & ntfy[i]);

      // R2
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == AW'(2*i)) |=> ((attn[i] & $past(attn[i])) == $past(attn[i])));

      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evs) |=> ((attn[i] & $past(evs)) == $past(evs)));

      // R3
      cond_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == AW'(2*i)) |=>
          (((attn[i] ^ $past(attn[i])) & $past(cmp ^ attn[i]) & ~$past(evs)) == '0));
    end
    if (NREG < DW) begin : g_res
      assign sum_v[DW-1-NREG:0] = '0;
    end
  endgenerate

  assign irq = |(sum_v & snt);

  always_comb begin
    rdata = '0;
    if (rd) begin
      for (int k = 0; k < NREG; k++) begin
        if (addr == AW'(2*k))   rdata = attn[k];
        if (addr == AW'(2*k+1)) rdata = ntfy[k];
      end
      if (addr == SUM_A) rdata = sum_v;
      if (addr == SNT_A) rdata = snt;
      if (addr == CMP_A) rdata = cmp;
    end
  end

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (snt != '0));

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0));
endmodule

// File: tb/tb_attn_bank.sv
`timescale 1ns/1ps
module tb_attn_bank;
  logic        clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [39:0] ev = '0;
  logic [7:0]  rdata;
  logic        irq;
  int errors = 0, checks = 0;
  int     exp_q[$];
  bit     irq_q[$];
  string  tag_q[$];

  attn_bank dut (.clk, .rst_n, .addr, .wdata, .wr, .rd, .rdata, .ev, .irq);

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rd && exp_q.size() > 0) begin
      int e; bit ei; string t;
      e = exp_q.pop_front(); ei = irq_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (rdata !== 8'(e) || irq !== ei) begin
        errors++;
        $display("FAIL %s: addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                 t, addr, rdata, irq, 8'(e), ei);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input logic [39:0] e = '0);
    addr = a; wdata = d; wr = 1; ev = e;
    cyc();
    wr = 0; ev = '0;
  endtask

  task automatic pulse(input logic [39:0] e);
    ev = e;
    cyc();
    ev = '0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input bit ei, input string t);
    addr = a; rd = 1;
    exp_q.push_back(int'(e)); irq_q.push_back(ei); tag_q.push_back(t);
    cyc();
    rd = 0;
  endtask

  task automatic idle_chk(input string t);
    addr = 4'h0; rd = 0;
    @(negedge clk);
    checks++;
    if (rdata !== 8'h00) begin
      errors++;
      $display("FAIL %s: rdata=%h expected 00", t, rdata);
    end
    cyc();
  endtask

  function automatic logic [39:0] evb(input int r, input int b);
    logic [39:0] v = '0;
    v[r*8+b] = 1'b1;
    return v;
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1;
    cyc();
    rd_chk(4'h0, 8'h07, 0, "R1 state reset");
    rd_chk(4'h2, 8'h00, 0, "R1 attn1 reset");
    rd_chk(4'h1, 8'h00, 0, "R1 notify0 reset");
    rd_chk(4'hC, 8'h00, 0, "R1 compare reset");
    rd_chk(4'hA, 8'h00, 0, "R1 summary reset");
    rd_chk(4'hB, 8'h00, 0, "R1 summary notify reset");
    idle_chk("R10 idle read");

    pulse(evb(1, 5) | evb(1, 0));
    rd_chk(4'h2, 8'h21, 0, "R2 event set");
    cyc(); cyc(); cyc();
    rd_chk(4'h2, 8'h21, 0, "R2 sticky");

    wr_reg(4'hC, 8'hFF);
    rd_chk(4'hC, 8'hFF, 0, "R5 compare readback");
    wr_reg(4'h2, 8'h00);
    rd_chk(4'h2, 8'h00, 0, "R3 full clear");

    pulse(evb(3, 7) | evb(3, 1));
    rd_chk(4'h6, 8'h82, 0, "R2 attn3 set");
    wr_reg(4'hC, 8'h80);
    wr_reg(4'h6, 8'h10);
    rd_chk(4'h6, 8'h12, 0, "R3 partial match");

    pulse(evb(4, 3));
    wr_reg(4'hC, 8'hFF);
    wr_reg(4'h8, 8'h00, evb(4, 3));
    rd_chk(4'h8, 8'h08, 0, "R4 set wins over clear");

    wr_reg(4'h3, 8'hA5);
    rd_chk(4'h3, 8'hA5, 0, "R5 notify readback");
    rd_chk(4'hA, 8'h00, 0, "R6 summary masked");
    wr_reg(4'h1, 8'h01);
    rd_chk(4'hA, 8'h80, 0, "R6 summary state");
    wr_reg(4'h7, 8'h10);
    rd_chk(4'hA, 8'h90, 0, "R6 summary request");
    wr_reg(4'h9, 8'hF7);
    rd_chk(4'hA, 8'h90, 0, "R6 mask excludes live bit");

    wr_reg(4'hA, 8'hFF);
    rd_chk(4'hA, 8'h90, 0, "R7 summary write ignored");

    wr_reg(4'hB, 8'h10);
    rd_chk(4'hB, 8'h10, 1, "R8 irq raised");
    wr_reg(4'hB, 8'h08);
    rd_chk(4'hB, 8'h08, 0, "R8 irq dropped");

    wr_reg(4'hE, 8'hFF);
    wr_reg(4'hD, 8'h55);
    rd_chk(4'hE, 8'h00, 0, "R9 unmapped read");
    rd_chk(4'hD, 8'h00, 0, "R9 unmapped read");
    rd_chk(4'hC, 8'hFF, 0, "R9 compare untouched");
    rd_chk(4'hB, 8'h08, 0, "R9 summary notify untouched");

    pulse(evb(4, 0));
    rd_chk(4'hA, 8'h98, 1, "R8 irq from event");
    rd_chk(4'h8, 8'h09, 1, "R2 attn4 value");

    cyc();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d pending, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule